// File: doc/BRIEF.md
# DRAM Training Command Queue Sequencer

This block holds a short list of DRAM commands prepared by training firmware and plays them out, one after another, on a DDR3-style command bus. Each of the four entries stores a row or column address, a bank number, a two-bit target rank, the three active-low command strobes (row strobe, column strobe, write enable) and a wait count. The wait count is the number of idle cycles the block inserts after issuing that entry.

Software fills the entries through a simple register-style write port. It then writes the control word with the start bit set and a command count, and the sequencer issues entries 0 through n-1 in order. Each command is driven for exactly one cycle. During wait cycles the bus idles with all strobes and chip selects high. A busy flag covers the whole run. A one-cycle done pulse follows the last wait cycle.

The write port selects its target with a 4-bit select. Bits [3:2] give the word kind: 0 is the address word, 1 is the command word, 2 is the wait word and 3 is the control word. Bits [1:0] give the entry index, and they are ignored for the control word.

Top module: `train_cmd_queue`

## Requirements
- R1: After reset, busy and done are 0, the three strobes and all four chip selects are high, and the address and bank outputs are 0.
- R2: The fields of each word sit at fixed bit positions.
  - Address word: address in bits 15:0, bank in bits 22:20, rank in bits 25:24.
  - Command word: row strobe level in bit 0, column strobe level in bit 1, write-enable level in bit 2.
  - Wait word: wait count in bits 31:16.
  - An issue cycle drives exactly these stored values.
- R3: A control write with bit 0 set, accepted while idle, makes entry 0 appear on the bus in the cycle right after the write's clock edge.
- R4: Control bits 19:16 hold (n-1)*4 for n commands, so bits 19:18 give n-1 and bits 17:16 are ignored. Entries 0 to n-1 are issued in ascending order, each exactly once.
- R5: Every command is driven for exactly one cycle. In every non-issue cycle the strobes and chip selects are all high and the address and bank are 0.
- R6: After an entry with wait count c, exactly c idle cycles follow before the next entry or the done cycle. A wait count of 0 lets the next entry issue on the next cycle.
- R7: In an issue cycle, exactly one chip select is low: chip select k for rank k. No chip select is low outside issue cycles.
- R8: A control write with bit 0 set that arrives while busy is ignored, and the run in progress continues unchanged.
- R9: Busy is high from the first issue cycle through the last wait cycle. In the following cycle busy is low and done is high for exactly one cycle.
- R10: A control write with bit 0 clear does not start the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 4 | Word select: [3:2] kind, [1:0] entry index |
| wr_data | input | 32 | Write data |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cmd_addr | output | 16 | Command address |
| cmd_bank | output | 3 | Bank address |
| cs_n | output | 4 | Per-rank chip selects, active low |
| busy | output | 1 | Queue running |
| done | output | 1 | One-cycle pulse after the run ends |

## Verification
The assertions assume that software does not rewrite the entry words while a run is in progress. Rewriting them mid-run would change the values being issued. The bench therefore loads all entries while the block is idle, and during a run it writes only control words. Wait counts are kept small so that each full expected trace stays short, except for one deliberate long wait that exercises the wide counter.

// File: rtl/tcq_pkg.sv
package tcq_pkg;
  parameter int Q_DEPTH = 4;
  parameter int IDX_W   = $clog2(Q_DEPTH);
  parameter int ADDR_W  = 16;
  parameter int BANK_W  = 3;
  parameter int RANK_W  = 2;
  parameter int WAIT_W  = 16;
  parameter int DATA_W  = 32;
  parameter int SEL_W   = IDX_W + 2;

  // field positions inside the written words
  parameter int BANK_LSB = 20;
  parameter int RANK_LSB = 24;
  parameter int WAIT_LSB = 16;
  parameter int CNT_LSB  = 16;
  parameter int CNT_W    = IDX_W + 2;

  typedef enum logic [1:0] {
    KIND_ADDR = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_WAIT = 2'd2,
    KIND_CTRL = 2'd3
  } word_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic              ras_n;
    logic              cas_n;
    logic              we_n;
    logic [WAIT_W-1:0] wait_cnt;
  } q_entry_t;

  // count field holds (n-1)*4: drop the two low bits to get the last index
  function automatic logic [IDX_W-1:0] f_last_index(input logic [CNT_W-1:0] field);
    return field[CNT_W-1:2];
  endfunction

  function automatic logic [(1<<RANK_W)-1:0] f_rank_onehot(input logic [RANK_W-1:0] r);
    logic [(1<<RANK_W)-1:0] v;
    v = '0;
    v[r] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/tcq_regfile.sv
module tcq_regfile
  import tcq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output q_entry_t          rd_entry,
  output logic              start_req,
  output logic [IDX_W-1:0]  start_last
);
  q_entry_t ents [Q_DEPTH];

  logic [1:0]       wr_kind;
  logic [IDX_W-1:0] wr_idx;
  assign wr_kind = wr_sel[SEL_W-1:IDX_W];
  assign wr_idx  = wr_sel[IDX_W-1:0];

  for (genvar g = 0; g < Q_DEPTH; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[g].addr     <= '0;
        ents[g].bank     <= '0;
        ents[g].rank     <= '0;
        ents[g].ras_n    <= 1'b1;
        ents[g].cas_n    <= 1'b1;
        ents[g].we_n     <= 1'b1;
        ents[g].wait_cnt <= '0;
      end else if (hit) begin
        case (wr_kind)
          KIND_ADDR: begin
            ents[g].addr <= wr_data[ADDR_W-1:0];
            ents[g].bank <= wr_data[BANK_LSB +: BANK_W];
            ents[g].rank <= wr_data[RANK_LSB +: RANK_W];
          end
          KIND_CMD: begin
            ents[g].ras_n <= wr_data[0];
            ents[g].cas_n <= wr_data[1];
            ents[g].we_n  <= wr_data[2];
          end
          KIND_WAIT: ents[g].wait_cnt <= wr_data[WAIT_LSB +: WAIT_W];
          default: ;
        endcase
      end
    end
  end

  assign rd_entry   = ents[rd_idx];
  assign start_req  = wr_en && (wr_kind == KIND_CTRL) && wr_data[0];
  assign start_last = f_last_index(wr_data[CNT_LSB +: CNT_W]);
endmodule

// File: rtl/tcq_sequencer.sv
module tcq_sequencer
  import tcq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [IDX_W-1:0]  start_last,
  input  logic [WAIT_W-1:0] cur_wait,
  output logic [IDX_W-1:0]  idx,
  output logic              issue,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

  seq_state_e        state;
  logic [IDX_W-1:0]  last_q;
  logic [WAIT_W-1:0] cnt;
  logic              at_last;

  assign at_last = (idx == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      last_q <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_req) begin
            state  <= S_ISSUE;
            idx    <= '0;
            last_q <= start_last;
          end
        end
        S_ISSUE: begin
          if (cur_wait != '0) begin
            state <= S_WAIT;
            cnt   <= cur_wait;
          end else if (at_last) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt == WAIT_W'(1)) begin
            if (at_last) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              state <= S_ISSUE;
              idx   <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign issue = (state == S_ISSUE);
  assign busy  = (state != S_IDLE);

  // R9: the end of a run is marked by done
  assert_done_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9: done is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: done never overlaps busy
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6: a non-zero wait forbids an issue in the following cycle
  assert_wait_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cur_wait != '0) |=> !issue);
  // R8: a start during a run does not disturb the latched count
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> $stable(last_q));
  // R4: the index only moves forward by one while running
  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(idx)) |-> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/tcq_rank_decode.sv
module tcq_rank_decode
  import tcq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue,
  input  logic [RANK_W-1:0]      rank,
  output logic [(1<<RANK_W)-1:0] cs_n
);
  localparam int NRANK = 1 << RANK_W;
  logic [NRANK-1:0] sel;
  assign sel = f_rank_onehot(rank);

  for (genvar r = 0; r < NRANK; r++) begin : g_cs
    assign cs_n[r] = ~(issue & sel[r]);
  end

  // R7: at most one chip select low, and one is low in every issue cycle
  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_cs_on_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ($countones(~cs_n) == 1));
endmodule

// File: rtl/train_cmd_queue.sv
module train_cmd_queue
  import tcq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [15:0]       cmd_addr,
  output logic [2:0]        cmd_bank,
  output logic [3:0]        cs_n,
  output logic              busy,
  output logic              done
);
  q_entry_t         cur;
  logic [IDX_W-1:0] idx;
  logic             issue;
  logic             start_req;
  logic [IDX_W-1:0] start_last;

  tcq_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_idx(idx), .rd_entry(cur),
    .start_req(start_req), .start_last(start_last)
  );

  tcq_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_last(start_last),
    .cur_wait(cur.wait_cnt), .idx(idx), .issue(issue), .busy(busy), .done(done)
  );

  tcq_rank_decode u_cs (
    .clk(clk), .rst_n(rst_n), .issue(issue), .rank(cur.rank), .cs_n(cs_n)
  );

  assign ras_n    = issue ? cur.ras_n : 1'b1;
  assign cas_n    = issue ? cur.cas_n : 1'b1;
  assign we_n     = issue ? cur.we_n  : 1'b1;
  assign cmd_addr = issue ? cur.addr  : '0;
  assign cmd_bank = issue ? cur.bank  : '0;

  // R5: outside a run the bus is idle
  assert_idle_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n && we_n && (&cs_n) && cmd_addr == '0));
  // R3: an accepted start from idle begins with entry 0 on the next cycle
  assert_start_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req) |=> (issue && idx == '0));
endmodule

// File: tb/sim_train_cmd_queue.sv
`timescale 1ns/1ps
module sim_train_cmd_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic ras_n, cas_n, we_n, busy, done;
  logic [15:0] cmd_addr;
  logic [2:0] cmd_bank;
  logic [3:0] cs_n;

  int checks = 0;
  int errors = 0;

  logic [15:0] e_addr [4];
  logic [2:0]  e_bank [4];
  logic [1:0]  e_rank [4];
  logic [2:0]  e_cmd  [4];
  int          e_wait [4];

  always #2.5 clk = ~clk;

  train_cmd_queue u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_addr(cmd_addr),
    .cmd_bank(cmd_bank), .cs_n(cs_n), .busy(busy), .done(done)
  );

  initial begin
    #(5ns * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // observed vector {ras,cas,we,addr,bank,cs_n,busy,done}
  function automatic logic [27:0] obs();
    return {ras_n, cas_n, we_n, cmd_addr, cmd_bank, cs_n, busy, done};
  endfunction

  function automatic logic [27:0] idle_vec(input logic b, input logic d);
    return {3'b111, 16'h0, 3'h0, 4'hF, b, d};
  endfunction

  function automatic logic [27:0] issue_vec(input int k);
    logic [3:0] cs;
    cs = 4'hF;
    cs[e_rank[k]] = 1'b0;
    return {e_cmd[k][0], e_cmd[k][1], e_cmd[k][2], e_addr[k], e_bank[k], cs, 1'b1, 1'b0};
  endfunction

  task automatic check(input logic [27:0] act, input logic [27:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = {kind, idx}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int k);
    wr(2'd0, 2'(k), {6'b0, e_rank[k], 1'b0, e_bank[k], 4'b0, e_addr[k]});
    wr(2'd1, 2'(k), {29'b0, e_cmd[k]});
    wr(2'd2, 2'(k), {16'(e_wait[k]), 16'h0});
  endtask

  // start with count field f, expected entries = (f>>2)+1; optionally inject a start mid-run
  task automatic run(input logic [3:0] f, input bit inject, input string tag);
    int n;
    int cyc;
    n = int'(f >> 2) + 1;
    wr(2'd3, 2'd0, {12'b0, f, 15'b0, 1'b1});
    cyc = 0;
    for (int k = 0; k < n; k++) begin
      check(obs(), issue_vec(k), tag);
      for (int w = 0; w < e_wait[k] + 1; w++) begin
        if (inject && cyc == 1) begin
          wr_en = 1'b1; wr_sel = 4'b1100; wr_data = 32'h0000_0001;
        end else begin
          wr_en = 1'b0;
        end
        cyc++;
        @(negedge clk);
        if (w < e_wait[k]) check(obs(), idle_vec(1'b1, 1'b0), tag);
      end
    end
    check(obs(), idle_vec(1'b0, 1'b1), tag);
    @(negedge clk);
    check(obs(), idle_vec(1'b0, 1'b0), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(obs(), idle_vec(1'b0, 1'b0), "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(obs(), idle_vec(1'b0, 1'b0), "R1 after reset");

    // sweep count and wait/rank/command patterns
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        e_addr[k] = 16'(16'h1357 * (k + 1) + 16'h0F0F * p);
        e_bank[k] = 3'(k + 3 * p);
        e_rank[k] = 2'(k + p);
        e_cmd[k]  = 3'(3 * k + p);
        e_wait[k] = (k + p) % 4;
        load(k);
      end
      for (int n = 1; n <= 4; n++) begin
        run(4'((n - 1) * 4), 1'b0, "R2 R3 R4 R5 R6 R7 R9 sweep");
      end
    end

    // R6 all-zero waits: back-to-back issue
    for (int k = 0; k < 4; k++) begin e_wait[k] = 0; load(k); end
    run(4'd12, 1'b0, "R6 back-to-back");

    // R4 low count bits ignored: 13 -> four entries
    run(4'd13, 1'b0, "R4 low bits ignored");

    // R8 start while busy ignored
    for (int k = 0; k < 4; k++) begin e_wait[k] = 2; load(k); end
    run(4'd8, 1'b1, "R8 start while busy");

    // R6 long wait
    e_wait[0] = 300; load(0);
    run(4'd0, 1'b0, "R6 long wait");

    // R10 control write with start bit clear
    wr(2'd3, 2'd0, 32'h000C_0000);
    for (int i = 0; i < 3; i++) begin
      check(obs(), idle_vec(1'b0, 1'b0), "R10 no start");
      @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule